// File: doc/BRIEF.md
# IN-Endpoint Control and Interrupt-Mask Register Bank

This block holds the software-visible control state for up to eight IN endpoints of a device-side USB controller. It also holds the shared interrupt-mask word. Software reaches it through a flat read/write port with combinational read data. The transfer engine reports events through one-cycle strobes for each endpoint: setup finished, transfer finished, disable acknowledged, bus error, OUT packet error and buffer-not-available. The block turns these events into latched status flags and one masked interrupt line for each endpoint.

Two bits in each control word, run and stop-request, hand an endpoint back and forth between software and hardware. Software can only raise them, and only hardware lowers them. When hardware lowers the run bit (and the stop-request bit, where it applies) because of an event, it does so one full cycle before the event's status flag appears. Software that sees the interrupt therefore always finds the endpoint already idle. Write-only command bits in the control word do not store anything: each becomes a one-cycle pulse toward the transfer engine.

Top module: `epctl_regbank`

## Requirements
- R1: After reset every register reads zero. The control word of endpoint n is at 0x900 + n*0x20, its status word is at 0x908 + n*0x20, and the mask word is at 0x810. Any other address reads zero.
- R2: Control bits [10:0] (packet size), [19:18] (endpoint kind) and [15] (active) are plain read/write fields. All other control bits except 31 and 30 read zero.
- R3: Control bits 29..26 are write-only commands that read as zero. Writing 1 to bit 29, 28, 27 or 26 of endpoint n pulses cmd_o[4n+3], [4n+2], [4n+1] or [4n] high for exactly the one cycle after the write.
- R4: Control bit 31 (run) is set when software writes 1 to it. Writing 0 to it leaves it unchanged.
- R5: Control bit 30 (stop request) is set by a software write only if bit 31 was already 1 before that write. Otherwise the write to bit 30 is ignored, even when the same write sets bit 31.
- R6: A disable acknowledge while bit 30 is 1 clears bits 31 and 30 together in one edge. A disable acknowledge while bit 30 is 0 changes nothing and raises no flag.
- R7: A setup-done or transfer-done strobe clears bit 31 of that endpoint.
- R8: Each event sets its status flag one cycle after the edge at which the matching control bits clear. Status bit positions: 0 transfer done, 1 endpoint disabled, 2 bus error, 3 setup done, 8 OUT packet error, 9 buffer not available.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event sets the same flag in the same cycle, the flag stays set.
- R10: Mask bits 0, 1, 2, 8 and 9 are read/write. Bits 7..3 and 31..10 read zero and ignore writes.
- R11: irq_o[n] is high when any status flag of endpoint n is set together with its mask bit (1 = enabled). The setup-done flag has no mask bit and always drives the interrupt.
- R12: When a hardware clear and a software set of bit 31 or bit 30 fall in the same cycle, the bit ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 12 | Register byte address |
| wen_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| setup_i | input | NUM_EP | Setup-done strobe for each endpoint |
| xfer_i | input | NUM_EP | Transfer-done strobe for each endpoint |
| disack_i | input | NUM_EP | Disable-acknowledge strobe for each endpoint |
| buserr_i | input | NUM_EP | Bus-error strobe for each endpoint |
| pkterr_i | input | NUM_EP | OUT-packet-error strobe for each endpoint |
| bna_i | input | NUM_EP | Buffer-not-available strobe for each endpoint |
| cmd_o | output | 4*NUM_EP | One-cycle command pulses, four for each endpoint |
| irq_o | output | NUM_EP | Masked interrupt for each endpoint |

## Verification
Two kinds of same-cycle collision matter here. The first is a software write that sets run or stop-request while a core strobe clears the same bit. The bench drives the register write and a transfer-done or disable-acknowledge strobe on the same clock, then reads the control word back and expects zero. The second is a write-1-to-clear of a status flag in the very cycle that flag latches. The bench places the clear one cycle after a bus-error strobe, so that the clear lands on the latching edge, and expects the flag to read back as set. The ordering of bit clear before flag is judged by reading the control word and the interrupt line in the cycle between the two edges.

// File: rtl/epctl_pkg.sv
package epctl_pkg;

    localparam int unsigned DW        = 32;
    localparam int unsigned CTL_BASE  = 32'h900;
    localparam int unsigned STS_OFS   = 32'h008;
    localparam int unsigned EP_STRIDE = 32'h020;
    localparam int unsigned MASK_ADDR = 32'h810;

    localparam int unsigned RUN_BIT   = 31;
    localparam int unsigned STOP_BIT  = 30;
    localparam int unsigned CMD_LSB   = 26;
    localparam int unsigned NCMD      = 4;
    localparam int unsigned NEVT      = 10;

    // event flag positions inside the status word
    localparam int unsigned EV_XFER   = 0;
    localparam int unsigned EV_DIS    = 1;
    localparam int unsigned EV_BUSERR = 2;
    localparam int unsigned EV_SETUP  = 3;
    localparam int unsigned EV_PKTERR = 8;
    localparam int unsigned EV_BNA    = 9;

    localparam logic [NEVT-1:0] EVT_VALID  = 10'b11_0000_1111;
    localparam logic [NEVT-1:0] MASK_VALID = 10'b11_0000_0111;
    localparam logic [NEVT-1:0] ALWAYS_ON  = 10'b00_0000_1000;

    typedef struct packed {
        logic            run;
        logic            stop;
        logic [1:0]      kind;
        logic            act;
        logic [10:0]     mps;
        logic [NCMD-1:0] cmd;
        logic [NEVT-1:0] pend;
        logic [NEVT-1:0] flags;
    } ep_state_t;

endpackage

// File: rtl/epctl_mask.sv
module epctl_mask
    import epctl_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [NEVT-1:0] wdata_i,
    output logic [NEVT-1:0] mask_o
);

    logic [NEVT-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (we_i) begin
            mask_d = wdata_i & MASK_VALID;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

    assert_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(mask_q));

endmodule

// File: rtl/epctl_slice.sv
module epctl_slice
    import epctl_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ctl_we_i,
    input  logic            sts_we_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            setup_i,
    input  logic            xfer_i,
    input  logic            disack_i,
    input  logic            buserr_i,
    input  logic            pkterr_i,
    input  logic            bna_i,
    input  logic [NEVT-1:0] mask_i,
    output logic [DW-1:0]   ctl_o,
    output logic [DW-1:0]   sts_o,
    output logic [NCMD-1:0] cmd_o,
    output logic            irq_o
);

    ep_state_t s_d, s_q;
    logic            stop_take;
    logic [NEVT-1:0] clr_mask;
    logic [NEVT-1:0] new_evt;
    logic            unused_wbits;

    assign unused_wbits = ^{wdata_i[25:20], wdata_i[17:16], wdata_i[14:11]};

    always_comb begin
        stop_take = disack_i && s_q.stop;
        clr_mask  = sts_we_i ? (wdata_i[NEVT-1:0] & EVT_VALID) : '0;

        new_evt            = '0;
        new_evt[EV_XFER]   = xfer_i;
        new_evt[EV_DIS]    = stop_take;
        new_evt[EV_BUSERR] = buserr_i;
        new_evt[EV_SETUP]  = setup_i;
        new_evt[EV_PKTERR] = pkterr_i;
        new_evt[EV_BNA]    = bna_i;

        s_d      = s_q;
        s_d.cmd  = '0;
        s_d.pend = new_evt;

        if (ctl_we_i) begin
            s_d.kind = wdata_i[19:18];
            s_d.act  = wdata_i[15];
            s_d.mps  = wdata_i[10:0];
            s_d.cmd  = wdata_i[CMD_LSB +: NCMD];
            if (wdata_i[RUN_BIT]) begin
                s_d.run = 1'b1;
            end
            if (wdata_i[STOP_BIT] && s_q.run) begin
                s_d.stop = 1'b1;
            end
        end

        // hardware clear has priority over any software set
        if (setup_i || xfer_i || stop_take) begin
            s_d.run = 1'b0;
        end
        if (stop_take) begin
            s_d.stop = 1'b0;
        end

        // flags latch one edge after the bits cleared; set beats clear
        s_d.flags = (s_q.flags & ~clr_mask) | s_q.pend;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o = {s_q.run, s_q.stop, 10'b0, s_q.kind, 2'b0, s_q.act, 4'b0, s_q.mps};
    assign sts_o = {{(DW-NEVT){1'b0}}, s_q.flags};
    assign cmd_o = s_q.cmd;
    assign irq_o = |(s_q.flags & (mask_i | ALWAYS_ON));

    assert_hw_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_we_i && wdata_i[RUN_BIT] && (setup_i || xfer_i)) |=> !s_q.run);

    assert_stop_needs_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.stop) |-> $past(s_q.run));

    assert_dis_flag_after_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.flags[EV_DIS]) |-> (!$past(s_q.run) && !$past(s_q.stop)));

    assert_xfer_flag_after_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.flags[EV_XFER]) |-> !$past(s_q.run));

    assert_stray_ack_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disack_i && !s_q.stop && s_q.run && !setup_i && !xfer_i) |=> s_q.run);

endmodule

// File: rtl/epctl_regbank.sv
module epctl_regbank
    import epctl_pkg::*;
#(
    parameter int unsigned NUM_EP = 8,
    parameter int unsigned AW     = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [AW-1:0]        addr_i,
    input  logic                 wen_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    input  logic [NUM_EP-1:0]    setup_i,
    input  logic [NUM_EP-1:0]    xfer_i,
    input  logic [NUM_EP-1:0]    disack_i,
    input  logic [NUM_EP-1:0]    buserr_i,
    input  logic [NUM_EP-1:0]    pkterr_i,
    input  logic [NUM_EP-1:0]    bna_i,
    output logic [4*NUM_EP-1:0]  cmd_o,
    output logic [NUM_EP-1:0]    irq_o
);

    localparam int unsigned MA = MASK_ADDR;

    logic [NEVT-1:0]   mask;
    logic              mask_hit;
    logic [NUM_EP-1:0] ctl_hit;
    logic [NUM_EP-1:0] sts_hit;
    logic [DW-1:0]     ctl_rd [NUM_EP];
    logic [DW-1:0]     sts_rd [NUM_EP];

    assign mask_hit = (addr_i == MA[AW-1:0]);

    epctl_mask u_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wen_i && mask_hit),
        .wdata_i (wdata_i[NEVT-1:0]),
        .mask_o  (mask)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        localparam int unsigned CA = CTL_BASE + i * EP_STRIDE;
        localparam int unsigned SA = CA + STS_OFS;

        assign ctl_hit[i] = (addr_i == CA[AW-1:0]);
        assign sts_hit[i] = (addr_i == SA[AW-1:0]);

        epctl_slice u_slice (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .ctl_we_i (wen_i && ctl_hit[i]),
            .sts_we_i (wen_i && sts_hit[i]),
            .wdata_i  (wdata_i),
            .setup_i  (setup_i[i]),
            .xfer_i   (xfer_i[i]),
            .disack_i (disack_i[i]),
            .buserr_i (buserr_i[i]),
            .pkterr_i (pkterr_i[i]),
            .bna_i    (bna_i[i]),
            .mask_i   (mask),
            .ctl_o    (ctl_rd[i]),
            .sts_o    (sts_rd[i]),
            .cmd_o    (cmd_o[NCMD*i +: NCMD]),
            .irq_o    (irq_o[i])
        );
    end

    always_comb begin
        rdata_o = '0;
        if (mask_hit) begin
            rdata_o = {{(DW-NEVT){1'b0}}, mask};
        end
        for (int i = 0; i < NUM_EP; i++) begin
            if (ctl_hit[i]) rdata_o = ctl_rd[i];
            if (sts_hit[i]) rdata_o = sts_rd[i];
        end
    end

endmodule

// File: tb/epctl_regbank_tb_top.sv
module epctl_regbank_tb_top;

    localparam int NEP = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     addr = '0;
    logic            wen = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NEP-1:0]  setup = '0, xfer = '0, disack = '0, buserr = '0, pkterr = '0, bna = '0;
    logic [4*NEP-1:0] cmd;
    logic [NEP-1:0]  irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    int          kq[$];
    logic [31:0] eq[$];
    logic [11:0] aq[$];
    string       tq[$];

    always #5 clk = ~clk;

    epctl_regbank dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wen_i(wen), .wdata_i(wdata),
        .rdata_o(rdata), .setup_i(setup), .xfer_i(xfer), .disack_i(disack),
        .buserr_i(buserr), .pkterr_i(pkterr), .bna_i(bna), .cmd_o(cmd), .irq_o(irq)
    );

    function automatic logic [11:0] ctl_a(int ep); return 12'(32'h900 + ep * 32'h20); endfunction
    function automatic logic [11:0] sts_a(int ep); return 12'(32'h908 + ep * 32'h20); endfunction
    localparam logic [11:0] MASK_A = 12'h810;

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        while (kq.size() > 0) begin
            int          k;
            logic [31:0] e;
            logic [31:0] act;
            logic [11:0] ad;
            string       t;
            k  = kq.pop_front();
            e  = eq.pop_front();
            ad = aq.pop_front();
            t  = tq.pop_front();
            if (k == 0)      act = rdata;
            else if (k == 1) act = {31'b0, irq[ad[2:0]]};
            else             act = cmd;
            nchk++;
            if (act !== e) begin
                nfail++;
                $display("FAIL %s: actual %h expected %h", t, act, e);
            end
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic push(int k, logic [11:0] a, logic [31:0] e, string t);
        kq.push_back(k); aq.push_back(a); eq.push_back(e); tq.push_back(t);
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string t);
        addr = a; push(0, a, e, t);
    endtask

    task automatic chk_irq(int ep, logic v, string t);
        push(1, 12'(ep), {31'b0, v}, t);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        tick(); addr = a; wdata = d; wen = 1'b1;
        tick(); wen = 1'b0;
    endtask

    // which: 0 setup 1 xfer 2 disack 3 buserr 4 pkterr 5 bna
    task automatic pulse(int which, int ep);
        tick();
        case (which)
            0: setup[ep]  = 1'b1;
            1: xfer[ep]   = 1'b1;
            2: disack[ep] = 1'b1;
            3: buserr[ep] = 1'b1;
            4: pkterr[ep] = 1'b1;
            default: bna[ep] = 1'b1;
        endcase
        tick();
        setup = '0; xfer = '0; disack = '0; buserr = '0; pkterr = '0; bna = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values and decode
        rd(ctl_a(0), 32'h0, "R1 ctl0 reset"); tick();
        rd(ctl_a(7), 32'h0, "R1 ctl7 reset"); tick();
        rd(MASK_A, 32'h0, "R1 mask reset"); chk_irq(0, 1'b0, "R1 irq reset"); tick();

        // R2/R3 fields and command pulses
        wr(ctl_a(3), 32'h3C08_81FF);
        rd(ctl_a(3), 32'h0008_81FF, "R2 R3 rw fields, cmd reads zero");
        push(2, 0, 32'h0000_F000, "R3 cmd pulse ep3"); tick();
        push(2, 0, 32'h0, "R3 cmd pulse one cycle"); tick();

        // R4 set-only run bit
        wr(ctl_a(3), 32'h8008_81FF);
        rd(ctl_a(3), 32'h8008_81FF, "R4 run set"); tick();
        wr(ctl_a(3), 32'h0008_81FF);
        rd(ctl_a(3), 32'h8008_81FF, "R4 write 0 ignored"); tick();

        // R5 stop needs prior run
        wr(ctl_a(5), 32'h4000_0000);
        rd(ctl_a(5), 32'h0, "R5 stop without run ignored"); tick();
        wr(ctl_a(5), 32'hC000_0000);
        rd(ctl_a(5), 32'h8000_0000, "R5 stop with same-write run ignored"); tick();
        wr(ctl_a(3), 32'hC008_81FF);
        rd(ctl_a(3), 32'hC008_81FF, "R5 stop accepted"); tick();

        // R10 mask
        wr(MASK_A, 32'hFFFF_FFFF);
        rd(MASK_A, 32'h0000_0307, "R10 mask reserved bits"); tick();

        // R6/R8 disable handshake ordering
        pulse(2, 3);
        rd(ctl_a(3), 32'h0008_81FF, "R6 ack clears run and stop");
        chk_irq(3, 1'b0, "R8 flag not yet raised"); tick();
        rd(sts_a(3), 32'h2, "R8 disabled flag latched");
        chk_irq(3, 1'b1, "R11 irq disabled"); tick();

        // R9 write one to clear
        wr(sts_a(3), 32'h2);
        rd(sts_a(3), 32'h0, "R9 w1c"); chk_irq(3, 1'b0, "R9 irq cleared"); tick();

        // R6 stray ack ignored
        pulse(2, 5);
        rd(ctl_a(5), 32'h8000_0000, "R6 stray ack ignored"); tick();
        rd(sts_a(5), 32'h0, "R6 no flag on stray ack"); tick();

        // R7 transfer done clears run, R11 masking
        pulse(1, 5);
        rd(ctl_a(5), 32'h0, "R7 xfer clears run"); chk_irq(5, 1'b0, "R8 xfer order"); tick();
        rd(sts_a(5), 32'h1, "R8 xfer flag"); chk_irq(5, 1'b1, "R11 xfer irq"); tick();
        wr(MASK_A, 32'h306);
        rd(sts_a(5), 32'h1, "R11 flag stays when masked");
        chk_irq(5, 1'b0, "R11 masked irq"); tick();

        // R12 collisions
        tick(); addr = ctl_a(6); wdata = 32'h8000_0000; wen = 1'b1; xfer[6] = 1'b1;
        tick(); wen = 1'b0; xfer = '0;
        rd(ctl_a(6), 32'h0, "R12 run set vs xfer clear"); tick();
        wr(ctl_a(6), 32'h8000_0000);
        wr(ctl_a(6), 32'h4000_0000);
        rd(ctl_a(6), 32'hC000_0000, "R5 stop after run"); tick();
        tick(); addr = ctl_a(6); wdata = 32'hC000_0000; wen = 1'b1; disack[6] = 1'b1;
        tick(); wen = 1'b0; disack = '0;
        rd(ctl_a(6), 32'h0, "R12 stop set vs ack clear"); tick();

        // R11 buffer-not-available masking
        wr(MASK_A, 32'h0);
        pulse(5, 2); tick();
        rd(sts_a(2), 32'h200, "R8 bna flag"); chk_irq(2, 1'b0, "R11 bna masked"); tick();
        wr(MASK_A, 32'h200);
        chk_irq(2, 1'b1, "R11 bna unmasked"); tick();
        pulse(4, 2); tick();
        rd(sts_a(2), 32'h300, "R8 pkterr flag"); tick();

        // R7/R11 setup done, no mask bit
        wr(MASK_A, 32'h0);
        wr(ctl_a(1), 32'h8000_0000);
        pulse(0, 1);
        rd(ctl_a(1), 32'h0, "R7 setup clears run"); chk_irq(1, 1'b0, "R8 setup order"); tick();
        rd(sts_a(1), 32'h8, "R8 setup flag"); chk_irq(1, 1'b1, "R11 setup always on"); tick();

        // R9 set beats clear in same cycle
        tick(); buserr[4] = 1'b1;
        tick(); buserr = '0; addr = sts_a(4); wdata = 32'h4; wen = 1'b1;
        tick(); wen = 1'b0;
        rd(sts_a(4), 32'h4, "R9 set wins over clear"); tick();

        // R1 unmapped address
        rd(12'h904, 32'h0, "R1 unmapped reads zero"); tick();
        tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule